// File: doc/BRIEF.md
# NMI Status and Speaker Control Register

This block is a single 8-bit register in I/O space. It gathers two non-maskable-interrupt error sources into sticky status bits: a system bus error event and a channel-check event. It also shows the live outputs of two interval-timer counters, holds the gate that lets counter 2 count, and drives a speaker pin from counter 2's output. Software reads the register to see which NMI source fired. It clears a source by writing that source's disable bit to 1 and then back to 0. It reads the same register to sample the timer outputs.

Each disable bit is active-low with respect to its source. While the bit is 1, the source is blocked and its status bit is held at 0. The combined NMI request output is high while either status bit is set. The interval timer itself is not part of this block. Its two counter outputs arrive as inputs, and the counting gate for counter 2 leaves as an output.

Top module: `nmi_spk_ctl`

## Requirements
- R1: Synchronous reset stores: bit 0 = 0 (counter gate), bit 1 = 0 (speaker enable), bit 2 = 0 (bus-error disable), bit 3 = 1 (channel-check disable). Both status bits (7 and 6) are 0. A read directly after reset returns 8'h28 when cnt2_out is 1 and cnt1_out is 0. After reset, nmi_req, spkr and cnt2_gate are all 0.
- R2: The register answers only at io_addr == BASE_ADDR (default 16'h0061). A write to any other address changes nothing. io_rdata is 8'h00 in every cycle without a read strobe at BASE_ADDR.
- R3: Bits 3..0 take io_wdata[3:0] on a selected write and read back unchanged. Write data in bits 7..4 is ignored.
- R4: Bit 7 sets on a cycle with serr_evt = 1 while bit 2 is 0. It then stays set until it is cleared.
- R5: Bit 6 sets on a cycle with iochk_evt = 1 while bit 3 is 0. It then stays set until it is cleared. Because bit 3 resets to 1, the channel-check source is blocked after reset.
- R6: While bit 2 (or bit 3) is 1, bit 7 (or bit 6) reads 0 and events from that source are not latched. Writing the disable bit to 1 and then to 0 clears the status, and the status stays clear after the bit returns to 0.
- R7: When a selected write and an event fall in the same cycle, the disable value being written decides. Writing 0 lets that event latch. Writing 1 drops it.
- R8: Bit 5 shows cnt2_out and bit 4 shows cnt1_out, taken in the same cycle as the read strobe. A read returns its data combinationally in the strobe cycle.
- R9: spkr is registered. It equals (bit 1 AND cnt2_out) as they stood one clock earlier.
- R10: cnt2_gate equals bit 0, from the clock edge that captures the write.
- R11: nmi_req is 1 exactly when bit 7 or bit 6 of the register is 1, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | ADDR_W | I/O address |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, zero unless selected read |
| serr_evt | input | 1 | Bus-error NMI event |
| iochk_evt | input | 1 | Channel-check NMI event |
| cnt1_out | input | 1 | Timer counter 1 output level |
| cnt2_out | input | 1 | Timer counter 2 output level |
| cnt2_gate | output | 1 | Counting enable for counter 2 |
| spkr | output | 1 | Speaker output |
| nmi_req | output | 1 | Combined NMI request |

## Verification
The risky overlap is an NMI event and a write to that source's disable bit landing in the same clock. The bench provokes it by raising serr_evt in the cycle that carries the register write. It does this twice: once with a write that clears the disable bit and once with a write that sets it. The bench then reads the register and checks that the status bit follows the value that was being written (latched, then dropped) and that nmi_req agrees with it.

// File: rtl/nmi_spk_pkg.sv
package nmi_spk_pkg;
  localparam int REG_W    = 8;
  localparam int NSRC     = 2;
  // source indices in the latch vector
  localparam int SRC_SERR = 0;
  localparam int SRC_IOCK = 1;
  // bit positions visible to software
  localparam int B_TGATE  = 0;
  localparam int B_SPKEN  = 1;
  localparam int B_SERDIS = 2;
  localparam int B_IOKDIS = 3;
  localparam int B_CNT1   = 4;
  localparam int B_CNT2   = 5;
  localparam int B_IOKST  = 6;
  localparam int B_SERST  = 7;
  localparam int CTRL_W   = 4;

  typedef struct packed {
    logic iok_dis;
    logic ser_dis;
    logic spk_en;
    logic tgate;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{iok_dis: 1'b1, ser_dis: 1'b0, spk_en: 1'b0, tgate: 1'b0};
endpackage

// File: rtl/nmi_spk_ioport.sv
module nmi_spk_ioport #(
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] BASE_ADDR = 16'h0061,
  parameter int          DW        = 8
) (
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [DW-1:0]     rd_byte,
  output logic              wr_hit,
  output logic [DW-1:0]     io_rdata
);
  localparam logic [ADDR_W-1:0] MATCH = ADDR_W'(BASE_ADDR);
  logic sel;

  always_comb begin
    sel      = (io_addr == MATCH);
    wr_hit   = io_wr & sel;
    io_rdata = (io_rd & sel) ? rd_byte : '0;
  end
endmodule

// File: rtl/nmi_spk_ctrl.sv
module nmi_spk_ctrl
  import nmi_spk_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_hit,
  input  logic [CTRL_W-1:0] wr_bits,
  input  logic              cnt2_out,
  output ctrl_t             ctrl_q,
  output ctrl_t             ctrl_nxt,
  output logic              spkr,
  output logic              cnt2_gate
);
  ctrl_t ctrl_r;
  logic  spk_r;

  always_comb begin
    ctrl_nxt = wr_hit ? ctrl_t'(wr_bits) : ctrl_r;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_r <= CTRL_RST;
      spk_r  <= 1'b0;
    end else begin
      ctrl_r <= ctrl_nxt;
      spk_r  <= ctrl_r.spk_en & cnt2_out;
    end
  end

  assign ctrl_q    = ctrl_r;
  assign spkr      = spk_r;
  assign cnt2_gate = ctrl_r.tgate;
endmodule

// File: rtl/nmi_spk_srclatch.sv
module nmi_spk_srclatch #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] dis_nxt,
  output logic [N-1:0] st,
  output logic         any_st
);
  logic [N-1:0] st_d;
  logic [N-1:0] st_q;
  logic         any_q;

  for (genvar i = 0; i < N; i++) begin : g_src
    always_comb begin
      st_d[i] = dis_nxt[i] ? 1'b0 : (st_q[i] | evt[i]);
    end
    always_ff @(posedge clk) begin
      if (rst) st_q[i] <= 1'b0;
      else     st_q[i] <= st_d[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) any_q <= 1'b0;
    else     any_q <= |st_d;
  end

  assign st     = st_q;
  assign any_st = any_q;
endmodule

// File: rtl/nmi_spk_ctl.sv
module nmi_spk_ctl
  import nmi_spk_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] BASE_ADDR = 16'h0061
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  input  logic              serr_evt,
  input  logic              iochk_evt,
  input  logic              cnt1_out,
  input  logic              cnt2_out,
  output logic              cnt2_gate,
  output logic              spkr,
  output logic              nmi_req
);
  logic            wr_hit;
  ctrl_t           ctrl_q;
  ctrl_t           ctrl_nxt;
  logic [NSRC-1:0] evt_v;
  logic [NSRC-1:0] dis_v;
  logic [NSRC-1:0] st_v;
  logic [REG_W-1:0] rd_byte;

  nmi_spk_ioport #(
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .DW(REG_W)
  ) u_port (
    .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .rd_byte(rd_byte), .wr_hit(wr_hit), .io_rdata(io_rdata)
  );

  nmi_spk_ctrl u_ctrl (
    .clk(clk), .rst(rst), .wr_hit(wr_hit), .wr_bits(io_wdata[CTRL_W-1:0]),
    .cnt2_out(cnt2_out), .ctrl_q(ctrl_q), .ctrl_nxt(ctrl_nxt),
    .spkr(spkr), .cnt2_gate(cnt2_gate)
  );

  always_comb begin
    evt_v           = '0;
    dis_v           = '0;
    evt_v[SRC_SERR] = serr_evt;
    evt_v[SRC_IOCK] = iochk_evt;
    dis_v[SRC_SERR] = ctrl_nxt.ser_dis;
    dis_v[SRC_IOCK] = ctrl_nxt.iok_dis;
  end

  nmi_spk_srclatch #(.N(NSRC)) u_lat (
    .clk(clk), .rst(rst), .evt(evt_v), .dis_nxt(dis_v),
    .st(st_v), .any_st(nmi_req)
  );

  always_comb begin
    rd_byte           = '0;
    rd_byte[B_TGATE]  = ctrl_q.tgate;
    rd_byte[B_SPKEN]  = ctrl_q.spk_en;
    rd_byte[B_SERDIS] = ctrl_q.ser_dis;
    rd_byte[B_IOKDIS] = ctrl_q.iok_dis;
    rd_byte[B_CNT1]   = cnt1_out;
    rd_byte[B_CNT2]   = cnt2_out;
    rd_byte[B_IOKST]  = st_v[SRC_IOCK];
    rd_byte[B_SERST]  = st_v[SRC_SERR];
  end
endmodule

// File: rtl/nmi_spk_ctl_chk.sv
module nmi_spk_ctl_chk #(
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] BASE_ADDR = 16'h0061
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] io_addr,
  input logic              io_wr,
  input logic              io_rd,
  input logic [7:0]        io_wdata,
  input logic [7:0]        io_rdata,
  input logic              cnt1_out,
  input logic              cnt2_out,
  input logic              cnt2_gate,
  input logic              spkr,
  input logic              nmi_req
);
  logic sel;
  assign sel = (io_addr == ADDR_W'(BASE_ADDR));

  // R1
  post_reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!nmi_req && !spkr && !cnt2_gate));
  // R2
  unsel_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !(io_rd && sel) |-> (io_rdata == 8'h00));
  // R6
  serr_masked_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (io_rd && sel && io_rdata[2]) |-> !io_rdata[7]);
  // R6
  iochk_masked_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (io_rd && sel && io_rdata[3]) |-> !io_rdata[6]);
  // R8
  live_counter_chk: assert property (@(posedge clk) disable iff (rst)
    (io_rd && sel) |-> (io_rdata[5] == cnt2_out && io_rdata[4] == cnt1_out));
  // R9
  spkr_source_chk: assert property (@(posedge clk) disable iff (rst)
    spkr |-> $past(cnt2_out));
  // R10
  gate_follows_write_chk: assert property (@(posedge clk) disable iff (rst)
    (io_wr && sel) |=> (cnt2_gate == $past(io_wdata[0])));
  // R11
  nmi_matches_status_chk: assert property (@(posedge clk) disable iff (rst)
    (io_rd && sel) |-> (nmi_req == (io_rdata[7] | io_rdata[6])));
endmodule

bind nmi_spk_ctl nmi_spk_ctl_chk #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) chk_i (
  .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
  .io_wdata(io_wdata), .io_rdata(io_rdata), .cnt1_out(cnt1_out),
  .cnt2_out(cnt2_out), .cnt2_gate(cnt2_gate), .spkr(spkr), .nmi_req(nmi_req)
);

// File: tb/nmi_spk_ctl_tb_top.sv
module nmi_spk_ctl_tb_top;
  localparam logic [15:0] BASE = 16'h0061;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] io_addr = BASE;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [7:0]  io_wdata = 8'h00;
  logic [7:0]  io_rdata;
  logic        serr_evt = 1'b0;
  logic        iochk_evt = 1'b0;
  logic        cnt1_out = 1'b0;
  logic        cnt2_out = 1'b1;
  logic        cnt2_gate;
  logic        spkr;
  logic        nmi_req;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  nmi_spk_ctl #(.ADDR_W(16), .BASE_ADDR(BASE)) dut_i (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .serr_evt(serr_evt),
    .iochk_evt(iochk_evt), .cnt1_out(cnt1_out), .cnt2_out(cnt2_out),
    .cnt2_gate(cnt2_gate), .spkr(spkr), .nmi_req(nmi_req)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0; io_addr = BASE;
  endtask

  task automatic io_read(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    #1 d = io_rdata;
    io_rd = 1'b0; io_addr = BASE;
  endtask

  task automatic pulse_serr();
    @(negedge clk); serr_evt = 1'b1;
    @(negedge clk); serr_evt = 1'b0;
  endtask

  task automatic pulse_iochk();
    @(negedge clk); iochk_evt = 1'b1;
    @(negedge clk); iochk_evt = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    io_read(BASE, d);
    chk("R1 reset byte", d, 8'h28);
    chk("R1 outputs after reset", {5'd0, nmi_req, spkr, cnt2_gate}, 8'h00);
  endtask

  task automatic t_rw();
    logic [7:0] d;
    io_write(BASE, 8'hF3);
    io_read(BASE, d);
    chk("R3 low nibble kept, high nibble ignored", d, 8'h23);
    io_write(BASE, 8'h0C);
    io_read(BASE, d);
    chk("R3 second pattern", d, 8'h2C);
  endtask

  task automatic t_decode();
    logic [7:0] d;
    io_write(16'h0060, 8'h03);
    io_read(BASE, d);
    chk("R2 foreign write ignored", d, 8'h2C);
    io_read(16'h0060, d);
    chk("R2 foreign read zero", d, 8'h00);
    #1 chk("R2 idle rdata zero", io_rdata, 8'h00);
  endtask

  task automatic t_serr();
    logic [7:0] d;
    io_write(BASE, 8'h08);
    pulse_serr();
    io_read(BASE, d);
    chk("R4 serr latched", d, 8'hA8);
    chk("R11 nmi on serr", {7'd0, nmi_req}, 8'h01);
    repeat (3) @(negedge clk);
    io_read(BASE, d);
    chk("R4 serr sticky", d, 8'hA8);
    io_write(BASE, 8'h0C);
    io_read(BASE, d);
    chk("R6 serr cleared while disabled", d, 8'h2C);
    chk("R11 nmi drops", {7'd0, nmi_req}, 8'h00);
    pulse_serr();
    io_read(BASE, d);
    chk("R6 masked serr not latched", d, 8'h2C);
    io_write(BASE, 8'h08);
    io_read(BASE, d);
    chk("R6 stays clear after re-enable", d, 8'h28);
  endtask

  task automatic t_iochk();
    logic [7:0] d;
    pulse_iochk();
    io_read(BASE, d);
    chk("R5 masked iochk ignored", d, 8'h28);
    io_write(BASE, 8'h00);
    pulse_iochk();
    io_read(BASE, d);
    chk("R5 iochk latched", d, 8'h60);
    chk("R11 nmi on iochk", {7'd0, nmi_req}, 8'h01);
    io_write(BASE, 8'h08);
    io_write(BASE, 8'h00);
    io_read(BASE, d);
    chk("R6 iochk clear sequence", d, 8'h20);
  endtask

  task automatic t_coincide();
    logic [7:0] d;
    io_write(BASE, 8'h04);
    @(negedge clk);
    io_wdata = 8'h00; io_wr = 1'b1; serr_evt = 1'b1;
    @(negedge clk);
    io_wr = 1'b0; serr_evt = 1'b0;
    io_read(BASE, d);
    chk("R7 enable write with event latches", d, 8'hA0);
    @(negedge clk);
    io_wdata = 8'h04; io_wr = 1'b1; serr_evt = 1'b1;
    @(negedge clk);
    io_wr = 1'b0; serr_evt = 1'b0;
    io_read(BASE, d);
    chk("R7 disable write with event drops", d, 8'h24);
    chk("R7 nmi low", {7'd0, nmi_req}, 8'h00);
  endtask

  task automatic t_counters();
    logic [7:0] d;
    @(negedge clk); cnt1_out = 1'b1; cnt2_out = 1'b0;
    io_read(BASE, d);
    chk("R8 live counter bits", d, 8'h14);
    @(negedge clk); cnt1_out = 1'b0; cnt2_out = 1'b1;
    io_read(BASE, d);
    chk("R8 live counter bits swapped", d, 8'h24);
  endtask

  task automatic t_speaker();
    io_write(BASE, 8'h02);
    @(negedge clk); cnt2_out = 1'b0;
    @(negedge clk);
    chk("R9 speaker low with counter low", {7'd0, spkr}, 8'h00);
    cnt2_out = 1'b1;
    #1 chk("R9 speaker still low before edge", {7'd0, spkr}, 8'h00);
    @(negedge clk);
    chk("R9 speaker follows counter", {7'd0, spkr}, 8'h01);
    io_write(BASE, 8'h00);
    @(negedge clk);
    chk("R9 speaker off when disabled", {7'd0, spkr}, 8'h00);
  endtask

  task automatic t_gate();
    io_write(BASE, 8'h01);
    chk("R10 gate on", {7'd0, cnt2_gate}, 8'h01);
    io_write(BASE, 8'h00);
    chk("R10 gate off", {7'd0, cnt2_gate}, 8'h00);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    t_reset();
    t_rw();
    t_decode();
    t_serr();
    t_iochk();
    t_coincide();
    t_counters();
    t_speaker();
    t_gate();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule